// File: doc/BRIEF.md
# Programmable FIFO Flag Router

This block produces the status flags for a pair of FIFOs that move data in opposite directions, A-to-B and B-to-A. From each FIFO's occupancy count it derives four conditions: Empty, Almost-Empty, Almost-Full and Full. The two almost thresholds are set per FIFO through offset registers. That gives eight internal flags in all.

A routing register picks which of the eight internal flags drives each of four flag output pins. Any pin may take any flag, and several pins may show the same flag. The FIFO memories and the pointer logic sit outside this block and supply the two occupancy counts. Configuration is written through a simple single-cycle write port.

Top module: `flag_router`

## Requirements
- R1: While `rst_ni` is low, `flag_o` is all zero. Reset loads both almost-offsets of both FIFOs with 8, and the routing default is: pin 0 takes A-to-B Empty, pin 1 takes A-to-B Full, pin 2 takes B-to-A Empty, pin 3 takes B-to-A Full.
- R2: Empty for a FIFO is true exactly when its count is 0, whatever the offsets are.
- R3: Full for a FIFO is true exactly when its count is at least DEPTH, whatever the offsets are.
- R4: Almost-Empty is true when the count is less than or equal to that FIFO's AE offset. An offset of 0 makes it equal to Empty.
- R5: Almost-Full is true when count + AF offset >= DEPTH. An offset of 0 makes it equal to Full, and an offset above DEPTH makes it always true.
- R6: Internal flag indices 0 to 7 are, in order: A-to-B Empty, AE, AF, Full, then B-to-A Empty, AE, AF, Full.
- R7: In the routing register, bits [3p+2:3p] hold the 3-bit flag index for pin p. Several pins may select the same index.
- R8: `flag_o` is registered. A change of count is visible on `flag_o` after the next rising edge. A register write accepted at edge k is visible on `flag_o` after edge k+1.
- R9: The write addresses are: 0 for the A-to-B AE offset, 1 for the A-to-B AF offset, 2 for the B-to-A AE offset, 3 for the B-to-A AF offset, and 4 for routing. Offsets take `wr_data_i[CNT_W-1:0]`. Writes to addresses 5 to 7 change nothing.
- R10: The flags of one FIFO depend only on that FIFO's own count and offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | REG_W | Write data, max(CNT_W, 3*NUM_PINS) bits |
| cnt_ab_i | input | CNT_W | A-to-B FIFO occupancy, CNT_W = clog2(DEPTH+1) |
| cnt_ba_i | input | CNT_W | B-to-A FIFO occupancy |
| flag_o | output | NUM_PINS | Routed flag pins |

## Verification
The bench builds the block with DEPTH of 16 and four pins. With that size the count can be swept through every value from empty to full in a few cycles. The 5-bit offsets can also exceed the depth, so the always-true Almost-Full case and the zero-offset cases are both reachable. Routing is stepped through all eight indices on one pin and also set with every pin on the same flag, while a scoreboard checks each result in the exact cycle the registered pins should change.

// File: rtl/flag_router_pkg.sv
package flag_router_pkg;
  localparam int NUM_FIFOS  = 2;
  localparam int FIFO_FLAGS = 4;
  localparam int NUM_FLAGS  = NUM_FIFOS * FIFO_FLAGS;
  localparam int SEL_W      = $clog2(NUM_FLAGS);
  localparam int ADDR_W     = 3;
  localparam int OFS_RESET  = 8;

  typedef enum logic [SEL_W-1:0] {
    FLG_AB_EMPTY  = 3'd0,
    FLG_AB_AEMPTY = 3'd1,
    FLG_AB_AFULL  = 3'd2,
    FLG_AB_FULL   = 3'd3,
    FLG_BA_EMPTY  = 3'd4,
    FLG_BA_AEMPTY = 3'd5,
    FLG_BA_AFULL  = 3'd6,
    FLG_BA_FULL   = 3'd7
  } flag_sel_e;

  typedef enum logic [ADDR_W-1:0] {
    REG_AE_AB = 3'd0,
    REG_AF_AB = 3'd1,
    REG_AE_BA = 3'd2,
    REG_AF_BA = 3'd3,
    REG_ROUTE = 3'd4
  } reg_addr_e;

  function automatic logic [SEL_W-1:0] pin_default(int p);
    case (p % 4)
      0:       return FLG_AB_EMPTY;
      1:       return FLG_AB_FULL;
      2:       return FLG_BA_EMPTY;
      default: return FLG_BA_FULL;
    endcase
  endfunction
endpackage

// File: rtl/flag_router_cfg.sv
module flag_router_cfg
  import flag_router_pkg::*;
#(
  parameter  int CNT_W    = 10,
  parameter  int NUM_PINS = 4,
  parameter  int REG_W    = 12,
  localparam int RT_W     = NUM_PINS * SEL_W
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [ADDR_W-1:0]                   wr_addr_i,
  input  logic [REG_W-1:0]                    wr_data_i,
  output logic [NUM_FIFOS-1:0][CNT_W-1:0]     ae_ofs_o,
  output logic [NUM_FIFOS-1:0][CNT_W-1:0]     af_ofs_o,
  output logic [RT_W-1:0]                     route_o
);
  function automatic logic [RT_W-1:0] route_reset();
    logic [RT_W-1:0] r;
    r = '0;
    for (int p = 0; p < NUM_PINS; p++) r[p*SEL_W +: SEL_W] = pin_default(p);
    return r;
  endfunction

  localparam logic [RT_W-1:0]  ROUTE_RST = route_reset();
  localparam logic [CNT_W-1:0] OFS_RST   = CNT_W'(OFS_RESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int f = 0; f < NUM_FIFOS; f++) begin
        ae_ofs_o[f] <= OFS_RST;
        af_ofs_o[f] <= OFS_RST;
      end
      route_o <= ROUTE_RST;
    end else if (wr_en_i) begin
      // per FIFO f: AE at 2f, AF at 2f+1
      for (int f = 0; f < NUM_FIFOS; f++) begin
        if (wr_addr_i == ADDR_W'(2*f))     ae_ofs_o[f] <= wr_data_i[CNT_W-1:0];
        if (wr_addr_i == ADDR_W'(2*f + 1)) af_ofs_o[f] <= wr_data_i[CNT_W-1:0];
      end
      if (wr_addr_i == REG_ROUTE) route_o <= wr_data_i[RT_W-1:0];
    end
  end
endmodule

// File: rtl/flag_router_cmp.sv
module flag_router_cmp
  import flag_router_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [CNT_W-1:0]      ae_ofs_i,
  input  logic [CNT_W-1:0]      af_ofs_i,
  output logic [FIFO_FLAGS-1:0] flags_o
);
  localparam logic [CNT_W:0] DEPTH_X = (CNT_W+1)'(DEPTH);

  logic [CNT_W:0] af_sum;

  // add instead of DEPTH-ofs: no underflow for offsets beyond depth
  assign af_sum = {1'b0, cnt_i} + {1'b0, af_ofs_i};

  always_comb begin
    flags_o[0] = (cnt_i == '0);
    flags_o[1] = (cnt_i <= ae_ofs_i);
    flags_o[2] = (af_sum >= DEPTH_X);
    flags_o[3] = ({1'b0, cnt_i} >= DEPTH_X);
  end
endmodule

// File: rtl/flag_router_mux.sv
module flag_router_mux
  import flag_router_pkg::*;
#(
  parameter  int NUM_PINS = 4,
  localparam int RT_W     = NUM_PINS * SEL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [RT_W-1:0]      route_i,
  output logic [NUM_PINS-1:0]  flag_o
);
  logic [NUM_PINS-1:0] pick;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pick[p] = flags_i[route_i[p*SEL_W +: SEL_W]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= pick;
  end
endmodule

// File: rtl/flag_router.sv
module flag_router
  import flag_router_pkg::*;
#(
  parameter  int DEPTH    = 512,
  parameter  int NUM_PINS = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int RT_W     = NUM_PINS * SEL_W,
  localparam int REG_W    = (CNT_W > RT_W) ? CNT_W : RT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [REG_W-1:0]    wr_data_i,
  input  logic [CNT_W-1:0]    cnt_ab_i,
  input  logic [CNT_W-1:0]    cnt_ba_i,
  output logic [NUM_PINS-1:0] flag_o
);
  logic [NUM_FIFOS-1:0][CNT_W-1:0] cnt_w;
  logic [NUM_FIFOS-1:0][CNT_W-1:0] ae_ofs_w;
  logic [NUM_FIFOS-1:0][CNT_W-1:0] af_ofs_w;
  logic [RT_W-1:0]                 route_w;
  logic [NUM_FLAGS-1:0]            flags_w;

  assign cnt_w[0] = cnt_ab_i;
  assign cnt_w[1] = cnt_ba_i;

  flag_router_cfg #(
    .CNT_W   (CNT_W),
    .NUM_PINS(NUM_PINS),
    .REG_W   (REG_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .ae_ofs_o (ae_ofs_w),
    .af_ofs_o (af_ofs_w),
    .route_o  (route_w)
  );

  for (genvar f = 0; f < NUM_FIFOS; f++) begin : g_fifo
    flag_router_cmp #(
      .DEPTH(DEPTH),
      .CNT_W(CNT_W)
    ) u_cmp (
      .cnt_i   (cnt_w[f]),
      .ae_ofs_i(ae_ofs_w[f]),
      .af_ofs_i(af_ofs_w[f]),
      .flags_o (flags_w[f*FIFO_FLAGS +: FIFO_FLAGS])
    );
  end

  flag_router_mux #(
    .NUM_PINS(NUM_PINS)
  ) u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flags_i(flags_w),
    .route_i(route_w),
    .flag_o (flag_o)
  );
endmodule

// File: rtl/flag_router_chk.sv
module flag_router_chk
  import flag_router_pkg::*;
#(
  parameter  int NUM_PINS = 4,
  localparam int RT_W     = NUM_PINS * SEL_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    wr_addr_i,
  input logic [NUM_FLAGS-1:0] flags_int,
  input logic [RT_W-1:0]      route_q,
  input logic [NUM_PINS-1:0]  flag_o
);
  logic past_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_q <= 1'b0;
    else         past_q <= 1'b1;
  end

  for (genvar f = 0; f < NUM_FIFOS; f++) begin : g_f
    a_r2_empty_implies_ae: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_int[f*FIFO_FLAGS] |-> flags_int[f*FIFO_FLAGS + 1]);
    a_r3_full_implies_af: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_int[f*FIFO_FLAGS + 3] |-> flags_int[f*FIFO_FLAGS + 2]);
    a_r3_not_empty_and_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_int[f*FIFO_FLAGS + 3] |-> !flags_int[f*FIFO_FLAGS]);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_p
    a_r8_pin_follows_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_q |-> (flag_o[p] == $past(flags_int[route_q[p*SEL_W +: SEL_W]])));
  end

  a_r9_route_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (wr_addr_i == REG_ROUTE)) |=> $stable(route_q));

  always_comb begin
    if (!rst_ni) a_r1_reset_pins_low: assert (flag_o == '0);
  end
endmodule

bind flag_router flag_router_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .flags_int(flags_w),
  .route_q  (route_w),
  .flag_o   (flag_o)
);

// File: tb/flag_router_tb_top.sv
`timescale 1ns/1ps
module flag_router_tb_top;
  localparam int DEPTH = 16;
  localparam int PINS  = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int REG_W = (CNT_W > 3*PINS) ? CNT_W : 3*PINS;

  typedef struct {
    int         due;
    logic [3:0] exp;
    string      req;
  } item_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [2:0]       wr_addr_i = '0;
  logic [REG_W-1:0] wr_data_i = '0;
  logic [CNT_W-1:0] cnt_ab_i = '0;
  logic [CNT_W-1:0] cnt_ba_i = '0;
  logic [PINS-1:0]  flag_o;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  item_t q[$];

  int m_cnt[2];
  int m_ae[2];
  int m_af[2];
  int m_sel[4];

  flag_router #(.DEPTH(DEPTH), .NUM_PINS(PINS)) dut_i (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [3:0] model_pins();
    logic [7:0] f;
    logic [3:0] r;
    for (int i = 0; i < 2; i++) begin
      f[4*i]     = (m_cnt[i] == 0);
      f[4*i + 1] = (m_cnt[i] <= m_ae[i]);
      f[4*i + 2] = (m_cnt[i] + m_af[i] >= DEPTH);
      f[4*i + 3] = (m_cnt[i] >= DEPTH);
    end
    for (int p = 0; p < 4; p++) r[p] = f[m_sel[p]];
    return r;
  endfunction

  function automatic int pack_route(int s0, int s1, int s2, int s3);
    return s0 | (s1 << 3) | (s2 << 6) | (s3 << 9);
  endfunction

  task automatic push(string req);
    item_t it;
    it.due = cyc + 1;
    it.exp = model_pins();
    it.req = req;
    q.push_back(it);
  endtask

  task automatic set_counts(int ab, int ba, string req);
    @(negedge clk_i);
    cnt_ab_i = CNT_W'(ab);
    cnt_ba_i = CNT_W'(ba);
    m_cnt[0] = ab;
    m_cnt[1] = ba;
    push(req);
  endtask

  task automatic write_reg(int addr, int data, string req);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_addr_i = 3'(addr);
    wr_data_i = REG_W'(data);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    case (addr)
      0: m_ae[0] = data & ((1 << CNT_W) - 1);
      1: m_af[0] = data & ((1 << CNT_W) - 1);
      2: m_ae[1] = data & ((1 << CNT_W) - 1);
      3: m_af[1] = data & ((1 << CNT_W) - 1);
      4: for (int p = 0; p < 4; p++) m_sel[p] = (data >> (3*p)) & 7;
      default: ;
    endcase
    push(req);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: sample 2 ns after the rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk_i);
      #2;
      while (q.size() > 0 && q[0].due <= cyc) begin
        it = q.pop_front();
        n_chk++;
        if (it.due != cyc || flag_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s cyc=%0d due=%0d actual=%b expected=%b",
                   it.req, cyc, it.due, flag_o, it.exp);
        end
      end
    end
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    m_cnt = '{0, 0};
    m_ae  = '{8, 8};
    m_af  = '{8, 8};
    m_sel = '{0, 3, 4, 7};
    #20;
    n_chk++;
    if (flag_o !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1 reset pins actual=%b expected=0000", flag_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 default routing, R2/R3 fixed flags, R10 independent counts
    for (int k = 0; k <= DEPTH; k++) set_counts(k, DEPTH - k, "R1 R2 R3 R10");

    // pins show AE/AF of both FIFOs with reset offsets of 8
    write_reg(4, pack_route(1, 2, 5, 6), "R6 R7 R9");
    for (int k = 0; k <= DEPTH; k++) set_counts(k, k, "R1 R4 R5");

    // zero offsets on A-to-B, out-of-range AE and small AF on B-to-A
    write_reg(0, 0, "R9");
    write_reg(1, 0, "R9");
    write_reg(2, 20, "R9");
    write_reg(3, 3, "R9");
    for (int k = 0; k <= DEPTH; k++) set_counts(k, DEPTH - k, "R4 R5 R10");

    // AF offset above depth: always asserted
    write_reg(1, 20, "R5");
    set_counts(0, 5, "R5");
    set_counts(9, 13, "R5");

    // unmapped addresses must leave config untouched
    write_reg(5, 0, "R9");
    write_reg(7, 12'hfff, "R9");
    set_counts(16, 0, "R9");
    set_counts(1, 14, "R9");

    // all pins on the same flag
    write_reg(4, pack_route(5, 5, 5, 5), "R7");
    set_counts(4, 3, "R7");
    set_counts(4, 16, "R7");

    // walk every index on pin 0, other pins fixed
    write_reg(1, 2, "R9");
    write_reg(2, 6, "R9");
    for (int s = 0; s < 8; s++) begin
      write_reg(4, pack_route(s, 3, 4, 7), "R6");
      set_counts(15, 6, "R6");
      set_counts(0, 16, "R6");
      set_counts(16, 0, "R6");
    end

    // one-cycle latency on back-to-back count changes
    write_reg(4, pack_route(0, 3, 4, 7), "R8");
    for (int k = 0; k < 6; k++) set_counts((k % 2) * DEPTH, ((k + 1) % 2) * DEPTH, "R8");

    repeat (4) @(negedge clk_i);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule